// File: doc/BRIEF.md
# Confidence-Filtered Load Address Predictor

This block guesses the effective address of a load instruction early in the pipeline, well before the address-generation stage computes it. A direct-mapped table is indexed by low bits of the load's instruction address. Each entry learns one of two patterns. The first is a stride pattern, where the next address is the last one plus a learned step; a step of zero covers a load that always uses the same address. The second is an alternating pattern, where the next address repeats the one seen two instances back.

A prediction is offered only when the entry's saturating confidence counter has reached a threshold. A wrong outcome on a trusted entry lowers its confidence but keeps its learned pattern, which gives hysteresis. New entries are created only after a small first-in-first-out filter has seen the same load miss twice, so loads that run once or wander randomly do not evict useful entries.

Actual addresses come back on a separate update port, possibly several cycles later. Each entry keeps speculative state that moves forward at every prediction, so back-to-back instances of one load are predicted correctly before their updates arrive.

Top module: `lap_predictor`

## Requirements
- R1: After reset the table and the allocation filter are empty, and `lk_hit` stays low for every lookup.
- R2: An update whose PC key (tag and index) misses in the table creates no entry the first time. It records the key in the filter instead. A second missing update with the same key, while that key is still held in the filter, creates the entry. The new entry has last address equal to the actual address, stride 0, stride mode, confidence 0 and nothing outstanding.
- R3: A load that always uses the same address is predicted with that address once confidence reaches the threshold.
- R4: A wrong update on an entry at confidence 0 relearns the stride as the actual address minus the previous last address.
- R5: When that relearn sees an actual address that equals the address from two updates back and differs from the last one, the entry switches to alternating mode. In alternating mode it predicts the address from two instances back.
- R6: Each lookup that hits the tag advances the entry's speculative address, so successive lookups return last+stride, last+2·stride, and so on. A correct update that leaves other predictions outstanding does not disturb this. A wrong update, or the update of the last outstanding prediction, resets the speculative address to the actual address.
- R7: Confidence is 2 bits and saturates at 0 and 3. A correct update raises it and a wrong one lowers it. While confidence is above 0, a wrong update keeps the stride and the mode.
- R8: `lk_hit` is high only when `lk_req` is high, the tag matches a valid entry and confidence is at least 2. `lk_addr` is 0 whenever `lk_hit` is low.
- R9: The index is PC bits [5:2] and the tag is PC bits [13:6]. A load with the same index but another tag gets no prediction. Its single miss update leaves the resident entry intact.
- R10: The filter holds 4 keys and replaces them in arrival order. A key pushed out by four newer missing keys must miss twice again before it is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request for a load being fetched |
| lk_pc | input | 32 | Instruction address of the load being looked up |
| lk_hit | output | 1 | A confident prediction is offered (combinational) |
| lk_addr | output | 32 | Predicted effective address, 0 when no hit |
| wb_valid | input | 1 | An executed load reports its actual address |
| wb_pc | input | 32 | Instruction address of the executed load |
| wb_addr | input | 32 | Actual effective address of the executed load |

## Verification
Directed sequences drive a constant-address load, a load stepping by 0x10, and a load alternating between two addresses. These separate the stride, zero-stride and alternating predictions, and show the allocation count and the confidence threshold from the exact update at which `lk_hit` first rises. A run of three lookups ahead of their updates, followed by interleaved updates and lookups, separates correct speculative advance from resynchronisation on every update. Wrong updates on a trusted entry show whether the stride survives, an aliasing PC and a burst of unrelated misses exercise the tag check and the filter's eviction order, and a pseudo-random mix with occasional address jumps is compared against the bench model on every cycle.

// File: rtl/lap_pkg.sv
package lap_pkg;

   typedef enum logic {
      LAP_STRIDE    = 1'b0,
      LAP_ALTERNATE = 1'b1
   } lap_mode_e;

endpackage

// File: rtl/lap_next_addr.sv
module lap_next_addr
   import lap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  lap_mode_e           mode,
   input  logic [ADDR_W-1:0]   base,
   input  logic [ADDR_W-1:0]   older,
   input  logic [ADDR_W-1:0]   stride,
   output logic [ADDR_W-1:0]   nxt
);

   always_comb begin
      if (mode == LAP_ALTERNATE) nxt = older;
      else                       nxt = base + stride;
   end

endmodule

// File: rtl/lap_train.sv
module lap_train
   import lap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CONF_W = 2
) (
   input  logic                correct,
   input  logic [CONF_W-1:0]   conf,
   input  logic [ADDR_W-1:0]   stride,
   input  lap_mode_e           mode,
   input  logic [ADDR_W-1:0]   last,
   input  logic [ADDR_W-1:0]   hist,
   input  logic [ADDR_W-1:0]   actual,
   output logic [CONF_W-1:0]   conf_n,
   output logic [ADDR_W-1:0]   stride_n,
   output lap_mode_e           mode_n
);

   localparam logic [CONF_W-1:0] CONF_MAX = '1;
   localparam logic [CONF_W-1:0] CONF_MIN = '0;

   always_comb begin
      conf_n   = conf;
      stride_n = stride;
      mode_n   = mode;
      if (correct) begin
         if (conf != CONF_MAX) conf_n = conf + 1'b1;
      end else if (conf != CONF_MIN) begin
         conf_n = conf - 1'b1;
      end else begin
         stride_n = actual - last;
         mode_n   = (actual == hist && actual != last) ? LAP_ALTERNATE : LAP_STRIDE;
      end
   end

endmodule

// File: rtl/lap_alloc_filter.sv
module lap_alloc_filter #(
   parameter int KEY_W = 12,
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              probe,
   input  logic [KEY_W-1:0]  probe_key,
   output logic              found,
   output logic [DEPTH-1:0]  hit_vec
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   logic [KEY_W-1:0] key_q [DEPTH];
   logic [DEPTH-1:0] live_q;
   logic [PTR_W-1:0] ptr_q;

   if (DEPTH < 2) begin : g_bad_depth
      $error("lap_alloc_filter: DEPTH must be at least 2");
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign hit_vec[s] = live_q[s] && (key_q[s] == probe_key);
   end

   assign found = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         ptr_q  <= '0;
      end else if (probe) begin
         if (found) begin
            live_q <= live_q & ~hit_vec;
         end else begin
            live_q[ptr_q] <= 1'b1;
            ptr_q         <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (probe && !found) key_q[ptr_q] <= probe_key;
   end

endmodule

// File: rtl/lap_predictor.sv
module lap_predictor
   import lap_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 4,
   parameter int TAG_W       = 8,
   parameter int CONF_W      = 2,
   parameter int CONF_THRESH = 2,
   parameter int PEND_W      = 3,
   parameter int FILT_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_addr,
   input  logic              wb_valid,
   input  logic [PC_W-1:0]   wb_pc,
   input  logic [ADDR_W-1:0] wb_addr
);

   localparam int ENTRIES = 1 << IDX_W;
   localparam int KEY_W   = IDX_W + TAG_W;
   localparam int IDX_HI  = IDX_W + 1;
   localparam int TAG_HI  = IDX_W + TAG_W + 1;
   localparam logic [CONF_W-1:0] THRESH   = CONF_W'(CONF_THRESH);
   localparam logic [PEND_W-1:0] PEND_MAX = '1;
   localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

   if (PC_W < KEY_W + 2) begin : g_bad_pc
      $error("lap_predictor: PC_W too narrow for index and tag");
   end
   if (CONF_THRESH < 1 || CONF_THRESH > (1 << CONF_W) - 1) begin : g_bad_thresh
      $error("lap_predictor: CONF_THRESH out of counter range");
   end
   if (PEND_W < 1 || IDX_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("lap_predictor: widths must be positive");
   end

   // ---------------- entry storage ----------------
   logic [ENTRIES-1:0] ev_q;
   logic [TAG_W-1:0]   tag_q    [ENTRIES];
   logic [ADDR_W-1:0]  last_q   [ENTRIES];
   logic [ADDR_W-1:0]  hist_q   [ENTRIES];
   logic [ADDR_W-1:0]  stride_q [ENTRIES];
   logic [ADDR_W-1:0]  spec_q   [ENTRIES];
   logic [ADDR_W-1:0]  spech_q  [ENTRIES];
   logic [CONF_W-1:0]  conf_q   [ENTRIES];
   logic [PEND_W-1:0]  pend_q   [ENTRIES];
   lap_mode_e          mode_q   [ENTRIES];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{lk_pc, wb_pc};

   // ---------------- lookup side ----------------
   logic [IDX_W-1:0]  l_idx;
   logic [TAG_W-1:0]  l_tag;
   logic              l_tag_hit;
   logic              l_adv;
   logic [ADDR_W-1:0] l_next;
   logic [PEND_W-1:0] l_pend_n;

   assign l_idx     = lk_pc[IDX_HI -: IDX_W];
   assign l_tag     = lk_pc[TAG_HI -: TAG_W];
   assign l_tag_hit = ev_q[l_idx] && (tag_q[l_idx] == l_tag);
   assign l_adv     = lk_req && l_tag_hit;

   lap_next_addr #(.ADDR_W(ADDR_W)) u_spec_next (
      .mode   (mode_q[l_idx]),
      .base   (spec_q[l_idx]),
      .older  (spech_q[l_idx]),
      .stride (stride_q[l_idx]),
      .nxt    (l_next)
   );

   assign lk_hit   = l_adv && (conf_q[l_idx] >= THRESH);
   assign lk_addr  = lk_hit ? l_next : '0;
   assign l_pend_n = (pend_q[l_idx] != PEND_MAX) ? pend_q[l_idx] + 1'b1 : pend_q[l_idx];

   // ---------------- update side ----------------
   logic [IDX_W-1:0]  w_idx;
   logic [TAG_W-1:0]  w_tag;
   logic              w_hit;
   logic              w_miss;
   logic              w_alloc;
   logic              f_found;
   logic [FILT_DEPTH-1:0] filt_match;
   logic [ADDR_W-1:0] w_last;
   logic [ADDR_W-1:0] w_expect;
   logic              w_correct;
   logic              w_resync;
   logic [PEND_W-1:0] w_pend;
   logic [PEND_W-1:0] w_pend_dec;
   logic [PEND_W-1:0] w_pend_n;
   logic [CONF_W-1:0] t_conf;
   logic [ADDR_W-1:0] t_stride;
   lap_mode_e         t_mode;

   assign w_idx  = wb_pc[IDX_HI -: IDX_W];
   assign w_tag  = wb_pc[TAG_HI -: TAG_W];
   assign w_hit  = wb_valid && ev_q[w_idx] && (tag_q[w_idx] == w_tag);
   assign w_miss = wb_valid && !w_hit;
   assign w_last = last_q[w_idx];
   assign w_pend = pend_q[w_idx];

   lap_next_addr #(.ADDR_W(ADDR_W)) u_commit_next (
      .mode   (mode_q[w_idx]),
      .base   (w_last),
      .older  (hist_q[w_idx]),
      .stride (stride_q[w_idx]),
      .nxt    (w_expect)
   );

   assign w_correct = (w_expect == wb_addr);
   assign w_resync  = !w_correct || (w_pend <= PEND_ONE);

   always_comb begin
      w_pend_dec = (w_pend == '0) ? '0 : w_pend - 1'b1;
      w_pend_n   = w_pend_dec;
      if (l_adv && (l_idx == w_idx) && (w_pend_dec != PEND_MAX))
         w_pend_n = w_pend_dec + 1'b1;
   end

   lap_train #(.ADDR_W(ADDR_W), .CONF_W(CONF_W)) u_train (
      .correct  (w_correct),
      .conf     (conf_q[w_idx]),
      .stride   (stride_q[w_idx]),
      .mode     (mode_q[w_idx]),
      .last     (w_last),
      .hist     (hist_q[w_idx]),
      .actual   (wb_addr),
      .conf_n   (t_conf),
      .stride_n (t_stride),
      .mode_n   (t_mode)
   );

   lap_alloc_filter #(.KEY_W(KEY_W), .DEPTH(FILT_DEPTH)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe     (w_miss),
      .probe_key ({w_tag, w_idx}),
      .found     (f_found),
      .hit_vec   (filt_match)
   );

   assign w_alloc = w_miss && f_found;

   // ---------------- state update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ev_q <= '0;
      else if (w_alloc) ev_q[w_idx] <= 1'b1;
   end

   // Lookup advance is written first; an update to the same entry overrides it.
   always_ff @(posedge clk) begin
      if (l_adv) begin
         spec_q[l_idx]  <= l_next;
         spech_q[l_idx] <= spec_q[l_idx];
         pend_q[l_idx]  <= l_pend_n;
      end
      if (w_hit) begin
         last_q[w_idx]   <= wb_addr;
         hist_q[w_idx]   <= w_last;
         conf_q[w_idx]   <= t_conf;
         stride_q[w_idx] <= t_stride;
         mode_q[w_idx]   <= t_mode;
         pend_q[w_idx]   <= w_pend_n;
         if (w_resync) begin
            spec_q[w_idx]  <= wb_addr;
            spech_q[w_idx] <= w_last;
         end
      end else if (w_alloc) begin
         tag_q[w_idx]    <= w_tag;
         last_q[w_idx]   <= wb_addr;
         hist_q[w_idx]   <= wb_addr;
         spec_q[w_idx]   <= wb_addr;
         spech_q[w_idx]  <= wb_addr;
         stride_q[w_idx] <= '0;
         conf_q[w_idx]   <= '0;
         pend_q[w_idx]   <= '0;
         mode_q[w_idx]   <= LAP_STRIDE;
      end
   end

endmodule

// File: rtl/lap_predictor_chk.sv
module lap_predictor_chk #(
   parameter int PC_W       = 32,
   parameter int FILT_DEPTH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  lk_req,
   input logic [PC_W-1:0]       lk_pc,
   input logic                  lk_hit,
   input logic                  wb_valid,
   input logic [PC_W-1:0]       wb_pc,
   input logic                  alloc,
   input logic [FILT_DEPTH-1:0] filt_match
);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !lk_hit);

   assert_alloc_from_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> wb_valid);

   assert_alloc_starts_cold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> !(lk_hit && (lk_pc == $past(wb_pc))));

   assert_hit_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_req);

   assert_filter_unique_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(filt_match));

endmodule

bind lap_predictor lap_predictor_chk #(.PC_W(PC_W), .FILT_DEPTH(FILT_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_req     (lk_req),
   .lk_pc      (lk_pc),
   .lk_hit     (lk_hit),
   .wb_valid   (wb_valid),
   .wb_pc      (wb_pc),
   .alloc      (w_alloc),
   .filt_match (filt_match)
);

// File: tb/lap_predictor_test.sv
`timescale 1ns/1ps
module lap_predictor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_addr;
   logic        wb_valid = 1'b0;
   logic [31:0] wb_pc = '0;
   logic [31:0] wb_addr = '0;

   int nchk = 0;
   int nerr = 0;
   logic        got_v;
   logic [31:0] got_a;

   always #5 clk = ~clk;

   lap_predictor uut (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_addr(lk_addr),
      .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_addr(wb_addr)
   );

   // ---------------- behavioural reference ----------------
   bit          mv  [16];
   logic [7:0]  mt  [16];
   logic [31:0] ml  [16];
   logic [31:0] mh  [16];
   logic [31:0] ms  [16];
   logic [31:0] mx  [16];
   logic [31:0] mst [16];
   int          mc  [16];
   int          mp  [16];
   bit          mm  [16];
   logic [11:0] fk  [4];
   bit          fv  [4];
   int          fp = 0;

   function automatic logic [31:0] mkpc(input int tg, input int ix);
      return 32'((tg << 6) | (ix << 2));
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic step(input string tag, input bit lr, input logic [31:0] lpc,
                       input bit wv, input logic [31:0] wpc, input logic [31:0] wa);
      int li, wi, j;
      bit lhit, whit, corr, fnd;
      logic [31:0] nxt, ea, expct, pl, ph, old_s;
      bit ev;
      int pc_, pp, pd;
      @(negedge clk);
      lk_req = lr; lk_pc = lpc; wb_valid = wv; wb_pc = wpc; wb_addr = wa;
      #1;
      got_v = lk_hit; got_a = lk_addr;
      li   = int'(lpc[5:2]);
      lhit = mv[li] && (mt[li] == lpc[13:6]);
      nxt  = mm[li] ? mx[li] : ms[li] + mst[li];
      ev   = lr && lhit && (mc[li] >= 2);
      ea   = ev ? nxt : 32'h0;
      chk({tag, " hit vs model"}, {31'h0, got_v}, {31'h0, ev});
      chk({tag, " addr vs model"}, got_a, ea);
      // model state update
      wi    = int'(wpc[5:2]);
      whit  = mv[wi] && (mt[wi] == wpc[13:6]);
      pl    = ml[wi]; ph = mh[wi]; pc_ = mc[wi]; pp = mp[wi];
      expct = mm[wi] ? ph : pl + mst[wi];
      corr  = (wa == expct);
      if (lr && lhit) begin
         old_s  = ms[li];
         ms[li] = nxt;
         mx[li] = old_s;
         mp[li] = (mp[li] < 7) ? mp[li] + 1 : 7;
      end
      if (wv && whit) begin
         ml[wi] = wa; mh[wi] = pl;
         if (corr) mc[wi] = (pc_ < 3) ? pc_ + 1 : 3;
         else if (pc_ > 0) mc[wi] = pc_ - 1;
         else begin
            mst[wi] = wa - pl;
            mm[wi]  = (wa == ph) && (wa != pl);
         end
         pd = (pp > 0) ? pp - 1 : 0;
         if (lr && lhit && li == wi && pd < 7) pd = pd + 1;
         mp[wi] = pd;
         if (!corr || pp <= 1) begin ms[wi] = wa; mx[wi] = pl; end
      end else if (wv) begin
         fnd = 1'b0;
         for (int k = 0; k < 4; k++)
            if (!fnd && fv[k] && fk[k] == wpc[13:2]) begin fnd = 1'b1; j = k; end
         if (fnd) begin
            fv[j] = 1'b0;
            mv[wi] = 1'b1; mt[wi] = wpc[13:6];
            ml[wi] = wa; mh[wi] = wa; ms[wi] = wa; mx[wi] = wa;
            mst[wi] = '0; mc[wi] = 0; mp[wi] = 0; mm[wi] = 1'b0;
         end else begin
            fk[fp] = wpc[13:2]; fv[fp] = 1'b1; fp = (fp + 1) % 4;
         end
      end
   endtask

   task automatic upd(input string tag, input logic [31:0] pc, input logic [31:0] a);
      step(tag, 1'b0, 32'h0, 1'b1, pc, a);
   endtask

   task automatic pred(input string tag, input logic [31:0] pc, input bit v, input logic [31:0] a);
      step(tag, 1'b1, pc, 1'b0, 32'h0, 32'h0);
      chk({tag, " hit expected"}, {31'h0, got_v}, {31'h0, v});
      chk({tag, " addr expected"}, got_a, a);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired (all requirements) got=running exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      logic [31:0] a_pc, b_pc, c_pc, d_pc, s;
      int cnt [8];
      for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mc[i] = 0; mp[i] = 0; end
      for (int i = 0; i < 4; i++) fv[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      a_pc = mkpc(3, 1); b_pc = mkpc(3, 2); c_pc = mkpc(3, 3); d_pc = mkpc(1, 5);

      // R1: empty after reset
      pred("R1 empty table", a_pc, 1'b0, 32'h0);

      // R2/R3: constant load, needs second miss then two correct updates
      upd("R2 first miss", a_pc, 32'h1000);
      upd("R2 alloc", a_pc, 32'h1000);
      upd("R7 conf up", a_pc, 32'h1000);
      pred("R2 R8 below threshold", a_pc, 1'b0, 32'h0);
      upd("R7 conf up", a_pc, 32'h1000);
      pred("R3 constant", a_pc, 1'b1, 32'h1000);
      step("R8 no request", 1'b0, a_pc, 1'b0, 32'h0, 32'h0);
      chk("R8 no request hit", {31'h0, got_v}, 32'h0);

      // R4/R6: stride 0x10
      upd("R4 train", b_pc, 32'h2000);
      upd("R4 train", b_pc, 32'h2010);
      upd("R4 relearn", b_pc, 32'h2020);
      upd("R4 train", b_pc, 32'h2030);
      upd("R4 train", b_pc, 32'h2040);
      pred("R4 stride", b_pc, 1'b1, 32'h2050);
      pred("R6 back to back", b_pc, 1'b1, 32'h2060);
      pred("R6 back to back", b_pc, 1'b1, 32'h2070);
      upd("R6 late update", b_pc, 32'h2050);
      pred("R6 ahead of updates", b_pc, 1'b1, 32'h2080);
      upd("R6 late update", b_pc, 32'h2060);
      upd("R6 late update", b_pc, 32'h2070);
      upd("R6 late update", b_pc, 32'h2080);
      pred("R6 drained", b_pc, 1'b1, 32'h2090);

      // R7: hysteresis keeps stride while confidence above 0
      upd("R7 wrong", b_pc, 32'h9000);
      pred("R7 stride kept", b_pc, 1'b1, 32'h9010);
      upd("R7 wrong again", b_pc, 32'h7000);
      pred("R7 below threshold", b_pc, 1'b0, 32'h0);

      // R5: alternating X,Y
      upd("R5 train", c_pc, 32'h3000);
      upd("R5 train", c_pc, 32'h3100);
      upd("R5 train", c_pc, 32'h3000);
      upd("R5 train", c_pc, 32'h3100);
      upd("R5 train", c_pc, 32'h3000);
      upd("R5 train", c_pc, 32'h3100);
      pred("R5 alternate", c_pc, 1'b1, 32'h3000);
      pred("R5 alternate", c_pc, 1'b1, 32'h3100);

      // R9: alias with other tag
      pred("R9 alias miss", mkpc(7, 1), 1'b0, 32'h0);
      upd("R9 alias update", mkpc(7, 1), 32'h4444);
      pred("R9 resident kept", a_pc, 1'b1, 32'h1000);

      // R10: filter eviction by four newer keys
      upd("R10 first", d_pc, 32'h5000);
      for (int k = 6; k < 10; k++) upd("R10 other", mkpc(1, k), 32'h6000);
      upd("R10 refilter", d_pc, 32'h5000);
      upd("R10 alloc", d_pc, 32'h5000);
      upd("R10 conf", d_pc, 32'h5000);
      pred("R10 evicted delays alloc", d_pc, 1'b0, 32'h0);
      upd("R10 conf", d_pc, 32'h5000);
      pred("R10 trained", d_pc, 1'b1, 32'h5000);

      // mixed traffic compared with the model on every cycle
      s = 32'h1234_5678;
      for (int k = 0; k < 8; k++) cnt[k] = 0;
      for (int n = 0; n < 600; n++) begin
         int pu, pq;
         logic [31:0] wa;
         bit jump;
         s = s * 32'd1103515245 + 32'd12345;
         pu = int'(s[18:16]); pq = int'(s[21:19]);
         jump = (s[27:24] == 4'h0);
         wa = 32'h8000 + 32'(pu * 32'h100) + 32'(cnt[pu] * 32'h20);
         if (jump) wa = s;
         if (s[12]) cnt[pu]++;
         step("R6 mixed traffic", s[10], mkpc(1 + pq[2], 8 + pq[1:0]),
              s[11], mkpc(1 + pu[2], 8 + pu[1:0]), wa);
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule